// File: doc/BRIEF.md
# Serial LED Frame Shifter

This block sends a 30-bit LED status word, over and over, to a chain of external serial LED drivers. Each transfer is a fixed frame of 36 serial clock periods. The block drives three outputs: a divided serial clock, a serial data line and a latch strobe. The serial clock is derived from the system clock by a programmable even ratio. Data moves on the falling edge of the serial clock, so every bit is steady when a receiver samples it on the rising edge.

The frame opens with a start bit, which lets a self-synchronising driver lock on. Two zero pads follow, then the thirty LED bits in ascending order, then three trailing zero pads. A mode input selects how the frame is used. In start-bit mode the latch strobe stays low, because the receiving driver synchronises on the start bit alone. In latch mode a strobe appears during the low half of the final clock period, which moves the shifted bits into the output registers of cascaded shift-register parts. The LED word is copied into a shadow register as each frame begins, so no frame ever mixes two words.

Top module: `led_frame_shifter`

## Requirements
- R1: While `rst_n` is low, `sclk_o`, `sdata_o` and `latch_o` are 0, and they stay 0 after release until the first divided period ends. The first rising edge of `sclk_o` comes 2*(`half_i`+1) system clocks after release.
- R2: Frames repeat without gaps, and each one is exactly 36 `sclk_o` periods long. In slot 1, the first period of a frame, `sdata_o` is 1 (the start bit).
- R3: In slots 2, 3, 34, 35 and 36, `sdata_o` is 0.
- R4: Slot k+4 carries `led_i[k]` for k = 0..29, with no inversion: an LED that is on is sent as 1.
- R5: `sdata_o` changes only when `sclk_o` falls, or when the very first frame starts while `sclk_o` is low. It never changes while `sclk_o` is high.
- R6: When `mode_i` = 1, `latch_o` goes high once per frame. It stays high for exactly one half period, during the low half of slot 36, and `sclk_o` is low for that whole time.
- R7: When `mode_i` = 0, `latch_o` stays 0.
- R8: Each high phase and each low phase of `sclk_o` lasts `half_i`+1 system clocks, which gives a 50% duty cycle and a ratio of 2*(`half_i`+1).
- R9: `led_i` is sampled once, at the start of slot 1. A change to `led_i` made later in a frame first shows up in the next frame.
- R10: The data pattern on `sdata_o` is the same in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0: start-bit mode, no latch; 1: latch mode |
| half_i | input | DIV_W | Half period of the serial clock, minus one, in system clocks |
| led_i | input | 30 | LED word; bit 0 is sent first |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data, updated on the falling edge of `sclk_o` |
| latch_o | output | 1 | Latch strobe, used in latch mode only |

## Verification
The bench reconstructs whole frames by sampling `sdata_o` on every rising edge of `sclk_o`. A design that put the data one slot off, reversed the bit order or let a pad go high would fail the frame comparison. It measures the width of every clock phase and the delay to the first edge, which catches an odd divide ratio or a missing start-up period. It times the latch strobe against the slot count and the clock level. A latch placed in the wrong slot, left high into the rising edge, or raised in start-bit mode is reported. It also changes the LED word in the middle of a frame; a design that samples `led_i` directly instead of a shadow copy would send a mixed frame.

// File: rtl/led_frame_pkg.sv
// Shared frame constants for the serial LED frame shifter.
// Assumes the fixed 36-slot layout: start, 2 pads, 30 data, 3 pads.
package led_frame_pkg;
    localparam int FRAME_SLOTS = 36;
    localparam int LED_BITS    = 30;
    localparam int START_SLOT  = 1;
    localparam int DATA_FIRST  = 4;
    localparam int DATA_LAST   = DATA_FIRST + LED_BITS - 1;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS + 1);

    typedef enum logic {
        MODE_START = 1'b0,
        MODE_LATCH = 1'b1
    } led_mode_e;
endpackage

// File: rtl/led_tick_gen.sv
// Half-period tick generator. It pulses tick_o once every half_i+1
// system clocks. Assumes half_i is quasi-static; if half_i drops below
// the running count, the next tick fires at once.
module led_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = (cnt >= half_i);

    // Count system clocks in the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/led_slot_seq.sv
// Slot sequencer. It toggles the serial clock on each tick and steps the
// slot number (1..36) on each falling edge. Out of reset it is idle with
// the clock low; the first tick opens slot 1 while the clock stays low.
module led_slot_seq
    import led_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic              sclk_o,
    output logic              started_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] slot_next_o,
    output logic              adv_o,
    output logic              rise_o
);
    // A new slot begins on a tick that ends a high phase or leaves idle.
    always_comb begin
        adv_o  = tick_i && (sclk_o || !started_o);
        rise_o = tick_i && !adv_o;
        if (!started_o || slot_o == SLOT_W'(FRAME_SLOTS))
            slot_next_o = SLOT_W'(START_SLOT);
        else
            slot_next_o = slot_o + 1'b1;
    end

    // Serial clock level, slot number and idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o    <= 1'b0;
            started_o <= 1'b0;
            slot_o    <= SLOT_W'(FRAME_SLOTS);
        end else if (adv_o) begin
            sclk_o    <= 1'b0;
            started_o <= 1'b1;
            slot_o    <= slot_next_o;
        end else if (rise_o) begin
            sclk_o    <= 1'b1;
        end
    end
endmodule

// File: rtl/led_out_stage.sv
// Output stage. It holds the shadow LED word and registers the serial
// data and latch lines, which change only when a new slot begins
// (the falling edge). The latch falls again on the next rising edge.
module led_out_stage
    import led_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_i,
    input  logic                rise_i,
    input  logic [SLOT_W-1:0]   slot_next_i,
    input  logic                mode_i,
    input  logic [LED_BITS-1:0] led_i,
    output logic                sdata_o,
    output logic                latch_o
);
    localparam int IDX_W = $clog2(LED_BITS);

    logic [LED_BITS-1:0] shadow;
    logic [SLOT_W-1:0]   offset;
    logic                bit_next;
    logic                latch_next;

    // Select the value that goes on the line in the slot about to begin.
    always_comb begin
        offset     = slot_next_i - SLOT_W'(DATA_FIRST);
        latch_next = (led_mode_e'(mode_i) == MODE_LATCH) &&
                     (slot_next_i == SLOT_W'(FRAME_SLOTS));
        if (slot_next_i == SLOT_W'(START_SLOT))
            bit_next = 1'b1;
        else if (slot_next_i >= SLOT_W'(DATA_FIRST) &&
                 slot_next_i <= SLOT_W'(DATA_LAST))
            bit_next = shadow[offset[IDX_W-1:0]];
        else
            bit_next = 1'b0;
    end

    // Copy the LED word as slot 1 opens.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (adv_i && slot_next_i == SLOT_W'(START_SLOT))
            shadow <= led_i;
    end

    // Register the serial data and latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_o <= 1'b0;
            latch_o <= 1'b0;
        end else if (adv_i) begin
            sdata_o <= bit_next;
            latch_o <= latch_next;
        end else if (rise_i) begin
            latch_o <= 1'b0;
        end
    end
endmodule

// File: rtl/led_frame_shifter.sv
// Top of the serial LED frame shifter. It joins the half-period tick
// generator, the slot sequencer and the output stage. All outputs are
// registered. Assumes mode_i and half_i change only between frames.
module led_frame_shifter
    import led_frame_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic [DIV_W-1:0]    half_i,
    input  logic [LED_BITS-1:0] led_i,
    output logic                sclk_o,
    output logic                sdata_o,
    output logic                latch_o
);
    logic              tick;
    logic              started;
    logic              adv;
    logic              rise;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_next;

    led_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_i),
        .tick_o (tick)
    );

    led_slot_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .sclk_o      (sclk_o),
        .started_o   (started),
        .slot_o      (slot),
        .slot_next_o (slot_next),
        .adv_o       (adv),
        .rise_o      (rise)
    );

    led_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .rise_i      (rise),
        .slot_next_i (slot_next),
        .mode_i      (mode_i),
        .led_i       (led_i),
        .sdata_o     (sdata_o),
        .latch_o     (latch_o)
    );
endmodule

// File: rtl/led_frame_checker.sv
// Protocol checker for led_frame_shifter, attached by bind below.
module led_frame_checker
    import led_frame_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              sclk_o,
    input logic              sdata_o,
    input logic              latch_o,
    input logic              tick,
    input logic              started,
    input logic [SLOT_W-1:0] slot
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!sclk_o && !sdata_o && !latch_o));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && slot == SLOT_W'(START_SLOT)) |-> sdata_o);

    p_pads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (started && (slot == SLOT_W'(2) || slot == SLOT_W'(3) ||
                     slot > SLOT_W'(DATA_LAST))) |-> !sdata_o);

    p_data_moves_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> !sclk_o);

    p_latch_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (!sclk_o && slot == SLOT_W'(FRAME_SLOTS)));

    p_latch_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_o) |-> $past(mode_i));

    p_clock_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $past(tick));
endmodule

bind led_frame_shifter led_frame_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .latch_o (latch_o),
    .tick    (tick),
    .started (started),
    .slot    (slot)
);

// File: tb/tb_led_frame_shifter.sv
// Directed bench for led_frame_shifter: a monitor rebuilds frames from
// the serial lines, and one task per scenario checks the results.
module tb_led_frame_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  half = 8'd1;
    logic [29:0] led = '0;
    logic        sclk_o, sdata_o, latch_o;

    int checks = 0;
    int errors = 0;

    // Monitor state
    int          rise_idx, clk_since, first_rise, frame_cnt;
    int          latch_cur, last_latch, latch_bad;
    int          phase_len, phase_bad, data_bad;
    bit          edge_seen;
    logic        prev_sclk, prev_sdata;
    logic [35:0] cur_bits, last_frame;

    led_frame_shifter #(.DIV_W(8)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .half_i  (half),
        .led_i   (led),
        .sclk_o  (sclk_o),
        .sdata_o (sdata_o),
        .latch_o (latch_o)
    );

    always #2 clk = ~clk;

    // Rebuild frames and time phases, sampling on the falling system edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            rise_idx = 0; clk_since = 0; first_rise = -1; frame_cnt = 0;
            latch_cur = 0; last_latch = -1; latch_bad = 0;
            phase_len = 0; phase_bad = 0; data_bad = 0; edge_seen = 0;
            prev_sclk = 0; prev_sdata = 0; cur_bits = '0;
        end else begin
            clk_since++;
            phase_len++;
            if (sclk_o != prev_sclk) begin
                if (edge_seen && phase_len != int'(half) + 1) phase_bad++;
                edge_seen = 1;
                phase_len = 0;
            end
            if (sdata_o != prev_sdata && !(prev_sclk && !sclk_o) && rise_idx != 0)
                data_bad++;
            if (latch_o) begin
                latch_cur++;
                if (sclk_o || (rise_idx % 36) != 35) latch_bad++;
            end
            if (sclk_o && !prev_sclk) begin
                rise_idx++;
                if (rise_idx == 1) first_rise = clk_since;
                cur_bits[(rise_idx - 1) % 36] = sdata_o;
                if ((rise_idx - 1) % 36 == 35) begin
                    last_frame = cur_bits;
                    last_latch = latch_cur;
                    latch_cur  = 0;
                    frame_cnt++;
                end
            end
            prev_sclk  = sclk_o;
            prev_sdata = sdata_o;
        end
    end

    function automatic logic [35:0] exp_frame(input logic [29:0] w);
        logic [35:0] f = '0;
        f[0] = 1'b1;
        for (int k = 0; k < 30; k++) f[3 + k] = w[k];
        return f;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic [7:0] h, input logic [29:0] w);
        @(negedge clk); #1;
        rst_n = 1'b0; mode = m; half = h; led = w;
        repeat (3) @(negedge clk);
        chk(!sclk_o && !sdata_o && !latch_o, "R1 outputs low in reset",
            {sclk_o, sdata_o, latch_o}, 0);
        #1 rst_n = 1'b1;
    endtask

    // Reset, start-up delay and a start-bit-mode frame.
    task automatic t_start_mode();
        logic [29:0] w = 30'h2A5_C3F1;
        do_reset(1'b0, 8'd1, w);
        @(negedge clk);
        chk(!sclk_o && !sdata_o && !latch_o, "R1 low after release",
            {sclk_o, sdata_o, latch_o}, 0);
        wait (frame_cnt >= 2);
        chk(first_rise == 4, "R1 first rise delay", first_rise, 4);
        chk(last_frame == exp_frame(w), "R2 R3 R4 frame content",
            last_frame, exp_frame(w));
        chk(last_latch == 0, "R7 no latch in start mode", last_latch, 0);
        chk(data_bad == 0, "R5 data only on falling edge", data_bad, 0);
        chk(phase_bad == 0, "R8 phase width", phase_bad, 0);
    endtask

    // Latch mode: same data, strobe in low half of slot 36.
    task automatic t_latch_mode();
        logic [29:0] w = 30'h1F0_0A55;
        do_reset(1'b1, 8'd2, w);
        wait (frame_cnt >= 2);
        chk(last_frame == exp_frame(w), "R10 frame equal in latch mode",
            last_frame, exp_frame(w));
        chk(last_latch == 3, "R6 latch one half period", last_latch, 3);
        chk(latch_bad == 0, "R6 latch placement", latch_bad, 0);
        chk(data_bad == 0, "R5 data stable in high phase", data_bad, 0);
        chk(first_rise == 6, "R1 first rise at ratio 6", first_rise, 6);
    endtask

    // Mid-frame change of the LED word reaches only the next frame.
    task automatic t_shadow();
        logic [29:0] a = 30'h0F0_F0F0;
        logic [29:0] b = 30'h30F_0F0F;
        do_reset(1'b1, 8'd0, a);
        wait (rise_idx >= 46);
        @(negedge clk); #1 led = b;
        wait (frame_cnt >= 2);
        chk(last_frame == exp_frame(a), "R9 old word kept in frame",
            last_frame, exp_frame(a));
        wait (frame_cnt >= 3);
        chk(last_frame == exp_frame(b), "R9 new word next frame",
            last_frame, exp_frame(b));
        chk(phase_bad == 0, "R8 ratio two phases", phase_bad, 0);
    endtask

    // Slow divide with all LEDs on: pads must still be zero.
    task automatic t_divide();
        logic [29:0] w = '1;
        do_reset(1'b0, 8'd5, w);
        wait (frame_cnt >= 2);
        chk(first_rise == 12, "R8 R1 first rise at ratio 12", first_rise, 12);
        chk(phase_bad == 0, "R8 phase width 6", phase_bad, 0);
        chk(last_frame == exp_frame(w), "R3 pads zero with all ones",
            last_frame, exp_frame(w));
        chk(last_latch == 0, "R7 latch stays low", last_latch, 0);
    endtask

    initial begin
        t_start_mode();
        t_latch_mode();
        t_shadow();
        t_divide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule